// File: doc/BRIEF.md
# Time-Slot Serial Data Framer

This block moves one frame of 16-bit receiver words onto a serial data line. While it does so, it collects the words that a host shifts in on a serial data input. A frame begins when a frame sync is seen high on a falling serial-clock edge. Starting with the next rising edge, the framer drives 80 bits MSB first: four channel words in a fixed order, then one appended word. It raises a frame-end flag during the final bit. Outside its own slot the data output is released by dropping its pad enable, so several framers can share one line. A cascaded framer can use the frame-end output of another framer as its frame sync, so that the two slots run back to back.

Two strap inputs are captured on the first system clock after the reset release and are then fixed. One selects whether the framer is the bus master. As master, the framer divides the system clock into the serial clock and emits a one-cycle frame sync at a programmable frame period. As slave, it oversamples an external serial clock and frame sync through synchronizers and finds their edges. The other strap selects parallel operation, which leaves the serial port idle. A frame sync that arrives while a slot is still running, before its final bit, is ignored, and a sticky error flag is set.

Top module: `tslot_framer`

## Requirements
- R1: While reset is asserted, sdo_oe_o, frame_end_o, sclk_o, fs_o, sync_err_o and rx_valid_o are all 0.
- R2: master_sel_i and parallel_sel_i are captured on the first system clock after the internal reset release; later changes to them have no effect until the next reset.
- R3: In master mode sclk_o is a square wave with a period of 2*HALF_DIV system clocks (at most half the system clock rate).
- R4: In master mode fs_o rises on a serial-clock rising edge, stays high for exactly one serial-clock cycle, and repeats every max(frame_len_i, 81) serial-clock cycles; a frame_len_i below 81 is treated as 81.
- R5: When frame sync is high on a falling serial-clock edge, the slot starts on the next rising edge. The 80 bits then go out one per rising edge, MSB first, in the order chan_words_i[63:48] (A-I), [47:32] (A-Q), [31:16] (B-I), [15:0] (B-Q), then app_word_i. The words are captured at the first bit.
- R6: sdo_oe_o is 1 for exactly the 80 bit periods of a slot and 0 otherwise (0 means high impedance); sdo_o is 0 while disabled.
- R7: frame_end_o is 1 only during the last bit period of a slot.
- R8: sdi_i is sampled on each falling serial-clock edge within a slot. After the 16th bit of word k (k = 0..4), rx_word_o holds that word MSB first, rx_idx_o equals k, and rx_valid_o pulses for one system clock.
- R9: A frame sync sampled during a slot before its last bit is ignored and sets sync_err_o, which stays 1 until reset. A frame sync sampled during the last bit starts a new slot on the very next rising edge, with no idle bit and no error.
- R10: In slave mode sclk_o and fs_o stay 0, and sclk_i and fs_i time the slots.
- R11: With parallel_sel_i captured as 1, the serial port stays idle: sdo_oe_o stays 0 whatever sclk_i and fs_i do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel_i | input | 1 | Strap: 1 = bus master |
| parallel_sel_i | input | 1 | Strap: 1 = parallel operation, serial port idle |
| frame_len_i | input | 12 | Master frame period in serial clocks |
| chan_words_i | input | 64 | Channel words, A-I in the top 16 bits |
| app_word_i | input | 16 | Appended word sent last |
| sclk_i | input | 1 | External serial clock (slave) |
| fs_i | input | 1 | External frame sync (slave) |
| sdi_i | input | 1 | Serial data input |
| sclk_o | output | 1 | Generated serial clock (master) |
| fs_o | output | 1 | Generated frame sync (master) |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Pad enable for sdo_o |
| frame_end_o | output | 1 | High during the last bit of a slot |
| sync_err_o | output | 1 | Sticky flag for a frame sync during a slot |
| rx_word_o | output | 16 | Last word received on sdi_i |
| rx_idx_o | output | 3 | Index of rx_word_o within the frame |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o updates |

## Verification
The hardest case to reach is a frame sync that lands on the falling edge of the final bit. In that case the slot must restart at once, with no idle bit, and no error may be flagged. A frame sync one bit earlier must instead be rejected. The bench drives the slave serial clock itself, one serial-clock phase at a time, so it can place a frame sync on any chosen bit. It does this at bit 79 for the cascade case and at bit 20 for the rejected case. It changes the word inputs between the two cascaded slots to show that the words are captured at the start of each slot.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  // Straps captured once after reset release.
  typedef struct packed {
    logic master;
    logic parallel;
  } strap_t;

  localparam strap_t STRAP_RST = '{master: 1'b0, parallel: 1'b1};
endpackage

// File: rtl/tslot_sync.sv
module tslot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tslot_edge_gen.sv
module tslot_edge_gen #(
  parameter int HALF_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic master,
  input  logic sclk_i,
  input  logic fs_i,
  input  logic sdi_i,
  output logic sclk_o,
  output logic rise_evt,
  output logic fall_evt,
  output logic fs_s,
  output logic sdi_s
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] dcnt_q, dcnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;
  logic             m_run;
  logic             sclk_s, sclk_dly_q;
  logic             sdi_sync;

  // Master divider: next state
  always_comb begin
    m_run  = run & master;
    tick   = m_run & (dcnt_q == DIV_W'(HALF_DIV - 1));
    dcnt_d = dcnt_q;
    sclk_d = sclk_q;
    if (!m_run) begin
      dcnt_d = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      dcnt_d = '0;
      sclk_d = ~sclk_q;
    end else begin
      dcnt_d = dcnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      sclk_q <= sclk_d;
    end
  end

  // Slave: synchronise external clock, sync and data
  tslot_sync #(.STAGES(SYNC_STAGES)) u_sclk (.clk(clk), .rst_n(rst_n), .d(sclk_i), .q(sclk_s));
  tslot_sync #(.STAGES(SYNC_STAGES)) u_fs   (.clk(clk), .rst_n(rst_n), .d(fs_i),   .q(fs_s));
  tslot_sync #(.STAGES(SYNC_STAGES)) u_sdi  (.clk(clk), .rst_n(rst_n), .d(sdi_i),  .q(sdi_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_dly_q <= 1'b0;
    else        sclk_dly_q <= sclk_s;
  end

  always_comb begin
    if (master) begin
      rise_evt = tick & ~sclk_q;
      fall_evt = tick &  sclk_q;
      sdi_s    = sdi_i;
    end else begin
      rise_evt = run &  sclk_s & ~sclk_dly_q;
      fall_evt = run & ~sclk_s &  sclk_dly_q;
      sdi_s    = sdi_sync;
    end
  end

  assign sclk_o = sclk_q;

  // R3: divider never leaves its range, edges never coincide
  assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dcnt_q <= DIV_W'(HALF_DIV - 1));
  assert_edge_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));
  // R3: master serial clock toggles only on a divider wrap
  assert_sclk_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (master && run && dcnt_q != DIV_W'(HALF_DIV - 1)) |=> $stable(sclk_q));
endmodule

// File: rtl/tslot_fs_master.sv
module tslot_fs_master #(
  parameter int SLOT_BITS = 80,
  parameter int FLEN_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              master,
  input  logic              rise_evt,
  input  logic [FLEN_W-1:0] frame_len_i,
  output logic              fs_o
);
  localparam int MIN_PER = SLOT_BITS + 1;

  logic [FLEN_W-1:0] fcnt_q, fcnt_d;
  logic [FLEN_W-1:0] period;
  logic              fs_q, fs_d;
  logic              m_run, step;

  always_comb begin
    period = (frame_len_i < FLEN_W'(MIN_PER)) ? FLEN_W'(MIN_PER) : frame_len_i;
    m_run  = run & master;
    step   = m_run & rise_evt;
    fcnt_d = fcnt_q;
    fs_d   = fs_q;
    if (!m_run) begin
      fcnt_d = '0;
      fs_d   = 1'b0;
    end else if (step) begin
      fs_d   = (fcnt_q == '0);
      fcnt_d = (fcnt_q >= period - FLEN_W'(1)) ? '0 : fcnt_q + FLEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      fs_q   <= fs_d;
    end
  end

  assign fs_o = fs_q;

  // R4: sync lasts one serial clock
  assert_fs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_q && rise_evt) |=> !fs_q);
  // R4: sync only moves on a serial rising edge
  assert_fs_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_q) |-> ($past(rise_evt) || !$past(m_run)));
  // R10: no sync output in slave mode
  assert_fs_slave_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !fs_q);
endmodule

// File: rtl/tslot_shifter.sv
module tslot_shifter #(
  parameter int WORD_W = 16,
  parameter int NWORDS = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         rise_evt,
  input  logic                         fall_evt,
  input  logic                         fs_smp,
  input  logic                         sdi_smp,
  input  logic [WORD_W*NWORDS-1:0]     frame_i,
  output logic                         sdo_o,
  output logic                         sdo_oe_o,
  output logic                         frame_end_o,
  output logic                         sync_err_o,
  output logic [WORD_W-1:0]            rx_word_o,
  output logic [$clog2(NWORDS)-1:0]    rx_idx_o,
  output logic                         rx_valid_o
);
  localparam int SLOT_BITS = WORD_W * NWORDS;
  localparam int WB_W      = $clog2(WORD_W);
  localparam int WI_W      = $clog2(NWORDS);

  logic                 act_q, act_d;
  logic                 pend_q, pend_d;
  logic                 sdo_q, sdo_d;
  logic                 oe_q, oe_d;
  logic                 fe_q, fe_d;
  logic                 err_q, err_d;
  logic [SLOT_BITS-1:0] sh_q, sh_d;
  logic [WB_W-1:0]      wbit_q, wbit_d, nxt_wbit;
  logic [WI_W-1:0]      widx_q, widx_d, nxt_widx;
  logic [WORD_W-1:0]    rxsh_q, rxsh_d;
  logic [WORD_W-1:0]    rxw_q, rxw_d;
  logic [WI_W-1:0]      rxi_q, rxi_d;
  logic                 rxv_q, rxv_d;
  logic                 is_last, nxt_last, word_end;

  // Position of the bit currently on the line
  always_comb begin
    word_end = (wbit_q == WB_W'(WORD_W - 1));
    is_last  = word_end && (widx_q == WI_W'(NWORDS - 1));
    nxt_wbit = word_end ? '0 : wbit_q + WB_W'(1);
    nxt_widx = word_end ? widx_q + WI_W'(1) : widx_q;
    nxt_last = (nxt_wbit == WB_W'(WORD_W - 1)) && (nxt_widx == WI_W'(NWORDS - 1));
  end

  // Next state
  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    sdo_d  = sdo_q;
    oe_d   = oe_q;
    fe_d   = fe_q;
    err_d  = err_q;
    sh_d   = sh_q;
    wbit_d = wbit_q;
    widx_d = widx_q;
    rxsh_d = rxsh_q;
    rxw_d  = rxw_q;
    rxi_d  = rxi_q;
    rxv_d  = 1'b0;

    // Falling edge: sample sync and serial input
    if (run && fall_evt) begin
      if (fs_smp) begin
        if (act_q && !is_last) err_d  = 1'b1;
        else                   pend_d = 1'b1;
      end
      if (act_q) begin
        rxsh_d = {rxsh_q[WORD_W-2:0], sdi_smp};
        if (word_end) begin
          rxw_d = {rxsh_q[WORD_W-2:0], sdi_smp};
          rxi_d = widx_q;
          rxv_d = 1'b1;
        end
      end
    end

    // Rising edge: drive the next bit
    if (run && rise_evt) begin
      if (pend_q) begin
        pend_d = 1'b0;
        act_d  = 1'b1;
        oe_d   = 1'b1;
        sdo_d  = frame_i[SLOT_BITS-1];
        sh_d   = {frame_i[SLOT_BITS-2:0], 1'b0};
        wbit_d = '0;
        widx_d = '0;
        fe_d   = 1'b0;
      end else if (act_q) begin
        if (is_last) begin
          act_d = 1'b0;
          oe_d  = 1'b0;
          sdo_d = 1'b0;
          fe_d  = 1'b0;
        end else begin
          sdo_d  = sh_q[SLOT_BITS-1];
          sh_d   = {sh_q[SLOT_BITS-2:0], 1'b0};
          wbit_d = nxt_wbit;
          widx_d = nxt_widx;
          fe_d   = nxt_last;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      fe_q   <= 1'b0;
      err_q  <= 1'b0;
      sh_q   <= '0;
      wbit_q <= '0;
      widx_q <= '0;
      rxsh_q <= '0;
      rxw_q  <= '0;
      rxi_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      sdo_q  <= sdo_d;
      oe_q   <= oe_d;
      fe_q   <= fe_d;
      err_q  <= err_d;
      sh_q   <= sh_d;
      wbit_q <= wbit_d;
      widx_q <= widx_d;
      rxsh_q <= rxsh_d;
      rxw_q  <= rxw_d;
      rxi_q  <= rxi_d;
      rxv_q  <= rxv_d;
    end
  end

  assign sdo_o       = sdo_q;
  assign sdo_oe_o    = oe_q;
  assign frame_end_o = fe_q;
  assign sync_err_o  = err_q;
  assign rx_word_o   = rxw_q;
  assign rx_idx_o    = rxi_q;
  assign rx_valid_o  = rxv_q;

  // R5: data and enable only change on a serial rising edge
  assert_sdo_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdo_q) || !$stable(oe_q)) |-> $past(rise_evt));
  // R6: released line carries no data and no frame end
  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_q |-> (!sdo_q && !fe_q));
  // R7: frame end lies inside the slot and lasts one bit
  assert_fe_in_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fe_q |-> oe_q);
  assert_fe_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && rise_evt) |=> !fe_q);
  // R8: received words appear only after a falling edge
  assert_rx_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |-> $past(fall_evt));
  // R9: error flag is sticky
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/tslot_framer.sv
module tslot_framer
  import tslot_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int CH_WORDS    = 4,
  parameter int HALF_DIV    = 2,
  parameter int FLEN_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              master_sel_i,
  input  logic                              parallel_sel_i,
  input  logic [FLEN_W-1:0]                 frame_len_i,
  input  logic [CH_WORDS*WORD_W-1:0]        chan_words_i,
  input  logic [WORD_W-1:0]                 app_word_i,
  input  logic                              sclk_i,
  input  logic                              fs_i,
  input  logic                              sdi_i,
  output logic                              sclk_o,
  output logic                              fs_o,
  output logic                              sdo_o,
  output logic                              sdo_oe_o,
  output logic                              frame_end_o,
  output logic                              sync_err_o,
  output logic [WORD_W-1:0]                 rx_word_o,
  output logic [$clog2(CH_WORDS+1)-1:0]     rx_idx_o,
  output logic                              rx_valid_o
);
  localparam int NWORDS    = CH_WORDS + 1;
  localparam int SLOT_BITS = NWORDS * WORD_W;

  logic [1:0] rs_q;
  logic       rst_int;
  strap_t     strap_q, strap_d;
  logic       armed_q, armed_d;
  logic       run;
  logic       rise_evt, fall_evt;
  logic       fs_s, sdi_s, fs_m, fs_smp;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  // Strap capture on first clock after release
  always_comb begin
    armed_d = 1'b1;
    strap_d = strap_q;
    if (!armed_q) begin
      strap_d.master   = master_sel_i;
      strap_d.parallel = parallel_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      armed_q <= 1'b0;
      strap_q <= STRAP_RST;
    end else begin
      armed_q <= armed_d;
      strap_q <= strap_d;
    end
  end

  assign run    = armed_q & ~strap_q.parallel;
  assign fs_smp = strap_q.master ? fs_m : fs_s;
  assign fs_o   = fs_m;

  tslot_edge_gen #(
    .HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk(clk), .rst_n(rst_int), .run(run), .master(strap_q.master),
    .sclk_i(sclk_i), .fs_i(fs_i), .sdi_i(sdi_i),
    .sclk_o(sclk_o), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .fs_s(fs_s), .sdi_s(sdi_s)
  );

  tslot_fs_master #(
    .SLOT_BITS(SLOT_BITS), .FLEN_W(FLEN_W)
  ) u_fsgen (
    .clk(clk), .rst_n(rst_int), .run(run), .master(strap_q.master),
    .rise_evt(rise_evt), .frame_len_i(frame_len_i), .fs_o(fs_m)
  );

  tslot_shifter #(
    .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_shift (
    .clk(clk), .rst_n(rst_int), .run(run),
    .rise_evt(rise_evt), .fall_evt(fall_evt),
    .fs_smp(fs_smp), .sdi_smp(sdi_s),
    .frame_i({chan_words_i, app_word_i}),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .frame_end_o(frame_end_o),
    .sync_err_o(sync_err_o), .rx_word_o(rx_word_o), .rx_idx_o(rx_idx_o),
    .rx_valid_o(rx_valid_o)
  );

  // R2: straps frozen once captured
  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_int)
    armed_q |=> $stable(strap_q));
  // R10: slave mode generates no clock or sync
  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int)
    !strap_q.master |-> (!sclk_o && !fs_o));
  // R11: parallel strap keeps the serial line released
  assert_parallel_idle_R11: assert property (@(posedge clk) disable iff (!rst_int)
    strap_q.parallel |-> !sdo_oe_o);
endmodule

// File: tb/sim_tslot_framer.sv
module sim_tslot_framer;
  localparam int HALF = 2;

  logic        clk, rst_n;
  logic        master_sel_i, parallel_sel_i;
  logic [11:0] frame_len_i;
  logic [63:0] chan_words_i;
  logic [15:0] app_word_i;
  logic        sclk_i, fs_i, sdi_i;
  logic        sclk_o, fs_o, sdo_o, sdo_oe_o, frame_end_o, sync_err_o;
  logic [15:0] rx_word_o;
  logic [2:0]  rx_idx_o;
  logic        rx_valid_o;

  logic [15:0] txw [5];
  logic [15:0] rxw [5];
  int n_chk = 0;
  int n_bad = 0;
  bit slave_phase = 0, saw_mclk = 0, par_phase = 0, saw_oe = 0;

  // {A-I, A-Q, B-I, B-Q, appended, sdi seed}
  localparam logic [95:0] VECS [4] = '{
    96'h8001_7ffe_a5a5_5a5a_0ac3_1234,
    96'hffff_0000_ffff_0000_c3c3_8000,
    96'h0001_8000_1234_fedc_ba98_ffff,
    96'h6b2d_94d2_0f0f_f0f0_3c3c_0000
  };

  assign chan_words_i = {txw[0], txw[1], txw[2], txw[3]};
  assign app_word_i   = txw[4];

  tslot_framer u0 (
    .clk(clk), .rst_n(rst_n), .master_sel_i(master_sel_i), .parallel_sel_i(parallel_sel_i),
    .frame_len_i(frame_len_i), .chan_words_i(chan_words_i), .app_word_i(app_word_i),
    .sclk_i(sclk_i), .fs_i(fs_i), .sdi_i(sdi_i), .sclk_o(sclk_o), .fs_o(fs_o),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .frame_end_o(frame_end_o), .sync_err_o(sync_err_o),
    .rx_word_o(rx_word_o), .rx_idx_o(rx_idx_o), .rx_valid_o(rx_valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (slave_phase && (sclk_o || fs_o)) saw_mclk = 1;
    if (par_phase && sdo_oe_o) saw_oe = 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(logic m, logic p);
    rst_n = 0; master_sel_i = m; parallel_sel_i = p;
    sclk_i = 0; fs_i = 0; sdi_i = 0;
    wait_clk(3);
    check("R1 reset outputs", {26'd0, sdo_oe_o, frame_end_o, sclk_o, fs_o, sync_err_o, rx_valid_o}, 32'd0);
    rst_n = 1;
    wait_clk(6);
  endtask

  task automatic s_rise(logic fs, logic d);
    sclk_i = 1; fs_i = fs; sdi_i = d;
    wait_clk(4);
  endtask

  task automatic s_fall();
    sclk_i = 0;
    wait_clk(4);
  endtask

  task automatic load_vec(logic [95:0] v);
    for (int k = 0; k < 5; k++) begin
      txw[k] = v[95-16*k -: 16];
      rxw[k] = v[15:0] + 16'(k * 16'h0f0f);
    end
  endtask

  // One slave slot: optional sync cycle, 80 bits, optional trailing idle bit
  task automatic run_frame(bit sync, int fs_bit, bit chain);
    logic [15:0] got [5];
    logic [15:0] exp_w [5];
    bit oe_bad = 0, fe_bad = 0;
    for (int k = 0; k < 5; k++) exp_w[k] = txw[k];
    if (sync) begin s_rise(1, 0); s_fall(); end
    for (int b = 0; b < 80; b++) begin
      s_rise(b == fs_bit, rxw[b/16][15-(b%16)]);
      got[b/16][15-(b%16)] = sdo_o;
      if (sdo_oe_o !== 1'b1) oe_bad = 1;
      if (frame_end_o !== (b == 79)) fe_bad = 1;
      s_fall();
      if (b % 16 == 15) begin
        check("R8 rx word", 32'(rx_word_o), 32'(rxw[b/16]));
        check("R8 rx index", 32'(rx_idx_o), b/16);
      end
    end
    for (int k = 0; k < 5; k++) check("R5 sdo word order", 32'(got[k]), 32'(exp_w[k]));
    check("R6 enable held through slot", 32'(oe_bad), 0);
    check("R7 frame end on last bit only", 32'(fe_bad), 0);
    if (!chain) begin
      s_rise(0, 0);
      check("R6 released after slot", 32'(sdo_oe_o), 0);
      check("R7 frame end cleared", 32'(frame_end_o), 0);
      s_fall();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t;
    frame_len_i = 12'd90;
    load_vec(VECS[0]);

    // Slave mode; then flip the strap pins, which must be ignored (R2)
    do_reset(0, 0);
    master_sel_i = 1; parallel_sel_i = 1;
    slave_phase = 1;

    // Table of vectors
    for (int v = 0; v < 4; v++) begin
      load_vec(VECS[v]);
      run_frame(1, -1, 0);
    end
    check("R2 strap change ignored, slots still run", 32'(saw_mclk), 0);
    check("R10 no clock or sync out in slave", {30'd0, sclk_o, fs_o}, 0);
    check("R9 no error without overlap", 32'(sync_err_o), 0);

    // Cascade: sync during last bit, new words for second slot
    load_vec(VECS[1]);
    run_frame(1, 79, 1);
    load_vec(VECS[2]);
    run_frame(0, -1, 0);
    check("R9 back-to-back accepted without error", 32'(sync_err_o), 0);

    // Sync mid-slot: ignored, flag sticks
    load_vec(VECS[3]);
    run_frame(1, 20, 0);
    check("R9 mid-slot sync flags error", 32'(sync_err_o), 1);
    wait_clk(20);
    check("R9 error sticky", 32'(sync_err_o), 1);
    slave_phase = 0;

    // Parallel strap: port stays idle
    do_reset(0, 1);
    par_phase = 1;
    s_rise(1, 0); s_fall();
    for (int b = 0; b < 20; b++) begin s_rise(b == 5, 1); s_fall(); end
    par_phase = 0;
    check("R11 serial port idle in parallel mode", 32'(saw_oe), 0);

    // Master mode
    load_vec(VECS[0]);
    frame_len_i = 12'd90;
    do_reset(1, 0);
    t = 0; while (sclk_o !== 1'b0 && t < 100) begin wait_clk(1); t++; end
    t = 0; while (sclk_o !== 1'b1 && t < 100) begin wait_clk(1); t++; end
    t = 0; while (sclk_o !== 1'b0 && t < 100) begin wait_clk(1); t++; end
    while (sclk_o !== 1'b1 && t < 100) begin wait_clk(1); t++; end
    check("R3 serial clock period", t, 2*HALF);

    t = 0; while (fs_o !== 1'b1 && t < 2000) begin wait_clk(1); t++; end
    t = 0; while (fs_o === 1'b1 && t < 100) begin wait_clk(1); t++; end
    check("R4 sync width one serial clock", t, 2*HALF);
    check("R5 master slot starts after sync", 32'(sdo_oe_o), 1);
    check("R5 master first bit is A-I MSB", 32'(sdo_o), 32'(txw[0][15]));

    t = 0; while (fs_o !== 1'b1 && t < 2000) begin wait_clk(1); t++; end
    t = 0;
    while (fs_o === 1'b1 && t < 2000) begin wait_clk(1); t++; end
    while (fs_o !== 1'b1 && t < 2000) begin wait_clk(1); t++; end
    check("R4 frame period programmed", t, 90*2*HALF);

    frame_len_i = 12'd10;
    t = 0;
    while (fs_o === 1'b1 && t < 2000) begin wait_clk(1); t++; end
    while (fs_o !== 1'b1 && t < 2000) begin wait_clk(1); t++; end
    check("R4 frame period clamped to 81", t, 81*2*HALF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule